// File: doc/BRIEF.md
# Keypad Event FIFO with Peek

This block is the event store of a keypad controller. A scanner upstream delivers one event at a time: a 7-bit key code and a flag saying whether the key went down or came up. The block packs each event into a byte and keeps up to 16 of them in a circular buffer, tracked by a start pointer and a length counter. A serial register interface, which is outside the block, reads the events back in two ways. A consuming read moves the start pointer forward before it returns a byte, so the slot under the start pointer is never returned by a consuming read. A peek returns the byte at a given offset from the start pointer and changes nothing.

The block also keeps three status bits. A keypad-interrupt request is set by every stored event. A general error bit and a sticky overflow bit are set when an event arrives while the buffer is full. While the error bit and the overflow bit are both set, new events are dropped silently until software acknowledges the status. A configuration clear empties the buffer. An acknowledge input clears the interrupt and error bits. The overflow bit stays set until reset.

Top module: `keypad_event_fifo`

## Requirements
- R1: After a synchronous reset, the fill level is 0 and the interrupt, error and overflow outputs are all 0.
- R2: An accepted push stores the byte {press, code}, with the press flag in bit 7 (1 = key down) and the code in bits 6:0. It is written at slot (start + length) mod 16, and the fill level rises by one on the next cycle.
- R3: popData shows 0x00 while the fill level is 1 or less, and a pop request then changes nothing. Otherwise popData shows the entry at (start + 1) mod 16, and a pop request advances start and lowers the fill level by one.
- R4: peekData shows 0x00 when peekOfs is greater than or equal to the fill level. Otherwise it shows the entry at (start + peekOfs) mod 16. A peek never changes any pointer.
- R5: A push that arrives while the fill level is 16 and the block is not frozen is dropped. It sets both ovfErr and errStatus on the next cycle.
- R6: While errStatus and ovfErr are both 1, pushes are ignored. The fill level and kpIrq are not changed by them, including after pops have made room.
- R7: Every accepted push sets kpIrq on the next cycle.
- R8: cfgClear sets start and length to 0 and clears kpIrq and errStatus. It overrides any push, pop or acknowledge in the same cycle and leaves ovfErr unchanged.
- R9: statusAck clears kpIrq and errStatus, and ovfErr holds until reset. A bit that is set in the same cycle as the acknowledge ends up 1. Freezing is decided from the status before the acknowledge.
- R10: A push and a pop in the same cycle are both carried out. The fill level does not change, and popData in that cycle shows the contents from before the push.
- R11: The start pointer and the write slot wrap modulo 16, and the fill level never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pushValid | input | 1 | Event present this cycle |
| pushCode | input | 7 | Key code of the event |
| pushPress | input | 1 | 1 = key pressed, 0 = released |
| popReq | input | 1 | Consuming read strobe |
| popData | output | 8 | Byte that a consuming read returns this cycle |
| peekOfs | input | 8 | Byte offset from start for a non-consuming read |
| peekData | output | 8 | Byte at the peek offset, or 0x00 |
| cfgClear | input | 1 | Configuration write: empties the buffer |
| statusAck | input | 1 | Interrupt status read: clears kpIrq and errStatus |
| fillLevel | output | 5 | Current length counter |
| kpIrq | output | 1 | Keypad interrupt status |
| errStatus | output | 1 | General error status |
| ovfErr | output | 1 | Sticky FIFO-overflow error |

## Verification
The hardest state to reach is the frozen state after room has been made again. To get there, the buffer must be filled, one more event must overflow it, and then several consuming reads must lower the fill level while the error bits stay set. Only then does a push show whether the freeze still holds. The bench drives this sequence directly. It then acknowledges and checks that pushes resume. A long run of alternating and simultaneous push and pop moves the start pointer around the ring several times. A seeded random phase then mixes clears, acknowledges and peek offsets past the fill level. Every cycle is compared against a queue-based model.

// File: rtl/kfifo_pkg.sv
package kfifo_pkg;
  typedef struct packed {
    logic doPush;
    logic doPop;
    logic doClear;
  } fifoStrobes_t;
endpackage

// File: rtl/kfifo_ctrl.sv
module kfifo_ctrl
  import kfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushValid,
  input  logic             popReq,
  input  logic             cfgClear,
  input  logic             statusAck,
  input  logic [LEN_W-1:0] len,
  output fifoStrobes_t     str,
  output logic             kpIrq,
  output logic             errStatus,
  output logic             ovfErr
);
  logic frozen, full, ovfHit;

  assign frozen = errStatus & ovfErr;
  assign full   = (len == LEN_W'(DEPTH));
  assign ovfHit = pushValid & ~frozen & full & ~cfgClear;

  assign str.doClear = cfgClear;
  assign str.doPush  = pushValid & ~frozen & ~full & ~cfgClear;
  assign str.doPop   = popReq & (len > LEN_W'(1)) & ~cfgClear;

  always_ff @(posedge clk) begin
    if (rst) begin
      kpIrq     <= 1'b0;
      errStatus <= 1'b0;
      ovfErr    <= 1'b0;
    end else begin
      ovfErr <= ovfErr | ovfHit;
      if (cfgClear) begin
        kpIrq     <= 1'b0;
        errStatus <= 1'b0;
      end else begin
        kpIrq     <= (kpIrq & ~statusAck) | str.doPush;
        errStatus <= (errStatus & ~statusAck) | ovfHit;
      end
    end
  end

  // R5
  overflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (pushValid && full && !frozen && !cfgClear) |=> (ovfErr && errStatus));

  // R6
  frozen_no_push_chk: assert property (@(posedge clk) disable iff (rst)
    (errStatus && ovfErr) |-> !str.doPush);

  // R7
  kp_set_chk: assert property (@(posedge clk) disable iff (rst)
    str.doPush |=> kpIrq);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovfErr |=> ovfErr);
endmodule

// File: rtl/kfifo_dp.sv
module kfifo_dp
  import kfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CODE_W = 7,
  parameter int OFS_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LEN_W = PTR_W + 1,
  localparam int BYTE_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobes_t      str,
  input  logic [CODE_W-1:0] pushCode,
  input  logic              pushPress,
  input  logic [OFS_W-1:0]  peekOfs,
  output logic [BYTE_W-1:0] popData,
  output logic [BYTE_W-1:0] peekData,
  output logic [LEN_W-1:0]  len
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  start, wrIdx, rdIdx, peekIdx;
  logic              peekHit;

  assign wrIdx   = start + len[PTR_W-1:0];
  assign rdIdx   = start + PTR_W'(1);
  assign peekIdx = start + peekOfs[PTR_W-1:0];
  assign peekHit = peekOfs < {{(OFS_W-LEN_W){1'b0}}, len};

  assign popData  = (len > LEN_W'(1)) ? mem[rdIdx] : '0;
  assign peekData = peekHit ? mem[peekIdx] : '0;

  always_ff @(posedge clk) begin
    if (str.doPush) mem[wrIdx] <= {pushPress, pushCode};
  end

  always_ff @(posedge clk) begin
    if (rst || str.doClear) begin
      start <= '0;
      len   <= '0;
    end else begin
      if (str.doPop) start <= rdIdx;
      len <= len + LEN_W'(str.doPush) - LEN_W'(str.doPop);
    end
  end

  // R11
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    len <= LEN_W'(DEPTH));

  // R10
  push_pop_len_chk: assert property (@(posedge clk) disable iff (rst)
    (str.doPush && str.doPop) |=> (len == $past(len)));

  // R8
  clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
    str.doClear |=> (len == '0));

  // R3
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (str.doPop && !str.doPush && !str.doClear) |=> (len == $past(len) - LEN_W'(1)));
endmodule

// File: rtl/keypad_event_fifo.sv
module keypad_event_fifo
  import kfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CODE_W = 7,
  parameter int OFS_W  = 8,
  localparam int LEN_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pushValid,
  input  logic [CODE_W-1:0] pushCode,
  input  logic              pushPress,
  input  logic              popReq,
  output logic [CODE_W:0]   popData,
  input  logic [OFS_W-1:0]  peekOfs,
  output logic [CODE_W:0]   peekData,
  input  logic              cfgClear,
  input  logic              statusAck,
  output logic [LEN_W-1:0]  fillLevel,
  output logic              kpIrq,
  output logic              errStatus,
  output logic              ovfErr
);
  fifoStrobes_t str;

  kfifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rst(rst), .pushValid(pushValid), .popReq(popReq),
    .cfgClear(cfgClear), .statusAck(statusAck), .len(fillLevel),
    .str(str), .kpIrq(kpIrq), .errStatus(errStatus), .ovfErr(ovfErr)
  );

  kfifo_dp #(.DEPTH(DEPTH), .CODE_W(CODE_W), .OFS_W(OFS_W)) uDp (
    .clk(clk), .rst(rst), .str(str), .pushCode(pushCode),
    .pushPress(pushPress), .peekOfs(peekOfs), .popData(popData),
    .peekData(peekData), .len(fillLevel)
  );
endmodule

// File: tb/tb_keypad_event_fifo.sv
module tb_keypad_event_fifo;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       pushValid, pushPress, popReq, cfgClear, statusAck;
  logic [6:0] pushCode;
  logic [7:0] peekOfs;
  logic [7:0] popData, peekData;
  logic [4:0] fillLevel;
  logic       kpIrq, errStatus, ovfErr;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";

  logic [7:0] q[$];
  bit mKp, mErr, mOvf;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_event_fifo dut (
    .clk(clk), .rst(rst), .pushValid(pushValid), .pushCode(pushCode),
    .pushPress(pushPress), .popReq(popReq), .popData(popData),
    .peekOfs(peekOfs), .peekData(peekData), .cfgClear(cfgClear),
    .statusAck(statusAck), .fillLevel(fillLevel), .kpIrq(kpIrq),
    .errStatus(errStatus), .ovfErr(ovfErr)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int n;
    n = q.size();
    chk("fillLevel (R2/R3)", fillLevel, n);
    chk("kpIrq (R7)", kpIrq, mKp);
    chk("errStatus (R5)", errStatus, mErr);
    chk("ovfErr (R5)", ovfErr, mOvf);
    chk("popData (R3)", popData, (n > 1) ? q[1] : 0);
    chk("peekData (R4)", peekData, (int'(peekOfs) < n) ? q[peekOfs] : 0);
  endtask

  task automatic modelStep();
    bit frz, full, dPush, dPop, hit;
    frz  = mErr && mOvf;
    full = (q.size() == 16);
    if (cfgClear) begin
      q.delete();
      mKp = 0;
      mErr = 0;
    end else begin
      dPush = pushValid && !frz && !full;
      hit   = pushValid && !frz && full;
      dPop  = popReq && q.size() > 1;
      if (dPop) void'(q.pop_front());
      if (dPush) q.push_back({pushPress, pushCode});
      mKp  = (mKp && !statusAck) || dPush;
      mErr = (mErr && !statusAck) || hit;
      mOvf = mOvf || hit;
    end
  endtask

  task automatic step(input bit pv, input int code, input bit pr, input bit pop,
                      input bit clr, input bit ack, input int ofs);
    pushValid = pv;
    pushCode  = 7'(code);
    pushPress = pr;
    popReq    = pop;
    cfgClear  = clr;
    statusAck = ack;
    peekOfs   = 8'(ofs);
    #1;
    compare();
    @(posedge clk);
    #1;
    modelStep();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    pushValid = 0; pushCode = 0; pushPress = 0; popReq = 0;
    cfgClear = 0; statusAck = 0; peekOfs = 0;
    mKp = 0; mErr = 0; mOvf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    tag = "R1";
    step(0, 0, 0, 0, 0, 0, 0);

    // R2 R4 R7: three events, peek sweep beyond length
    tag = "R2";
    step(1, 7'h3c, 1, 0, 0, 0, 0);
    step(1, 7'h15, 0, 0, 0, 0, 0);
    step(1, 7'h7f, 1, 0, 0, 0, 1);
    tag = "R4";
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, i);

    // R3: pop down to one, then pop at length 1 yields zero
    tag = "R3";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 0);

    // R9: acknowledge
    tag = "R9";
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);

    // R10: simultaneous push and pop
    tag = "R10";
    step(1, 7'h01, 0, 1, 0, 0, 0);
    step(1, 7'h02, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 7'h10 + i, i[0], 1, 0, 0, 1);

    // R5: fill to 16 then overflow
    tag = "R5";
    while (q.size() < 16) step(1, 7'h20 + q.size(), 1, 0, 0, 0, 15);
    step(1, 7'h55, 1, 0, 0, 0, 15);
    step(0, 0, 0, 0, 0, 0, 16);

    // R6: frozen, pushes ignored even after room made
    tag = "R6";
    step(1, 7'h66, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, 0);
    step(1, 7'h67, 1, 0, 0, 0, 2);
    step(1, 7'h68, 1, 1, 0, 0, 2);

    // R9: ack unfreezes, overflow bit stays
    tag = "R9";
    step(1, 7'h69, 1, 0, 0, 1, 0);
    step(1, 7'h6a, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);

    // R8: clear overrides concurrent push and pop
    tag = "R8";
    step(1, 7'h70, 1, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);

    // R11: many laps around the ring
    tag = "R11";
    for (int i = 0; i < 60; i++) step(1, i, i[1], (i % 3) != 0, 0, 0, i % 6);

    // R8 R9 R10: random mix
    tag = "R10";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom(i + 7);
      step(r[0] | r[1], r[14:8], r[2], r[3] & r[4], (r[9:5] == 0), (r[13:10] == 0), r[20:16] % 20);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule